// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The host hands over one access at a time: an address, a read/write flag and write data, through a valid/ready handshake. The controller then runs the RAM's pins through a timed sequence. Those pins are a 17-bit address, a low-true and a high-true chip select, a low-true output enable, a low-true write strobe and an 8-bit bidirectional data bus. When a read finishes, one pulse returns the captured byte.

Each phase length is a whole number of system clocks. The controller computes it at elaboration as the ceiling of the RAM's timing figure over the clock period, and it never uses fewer than one cycle. The default figures are for the fastest grade: 45 ns access, 20 ns output-enable access, 15 ns release-to-float, with a 50 MHz clock. Between accesses the RAM is deselected, so it stays in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, req_ready_o=1, rsp_valid_o=0, ram_cs_n_o=1, ram_cs_o=0, ram_oe_n_o=1 and ram_we_n_o=1.
- R2: The RAM is selected (ram_cs_n_o=0 and ram_cs_o=1) only while an access is in progress. Whenever req_ready_o=1, it is deselected (ram_cs_n_o=1, ram_cs_o=0).
- R3: A read holds ram_we_n_o=1 and ram_oe_n_o=0 with a stable address for exactly N_RD cycles. N_RD is the ceiling of the largest of the read-cycle, address-access and output-enable-access times over the clock period (3 at the defaults). The bus value at the last edge of that window appears on rsp_rdata_o.
- R4: A write keeps ram_oe_n_o=1 throughout. Address and data are valid and the RAM is selected for at least one cycle before ram_we_n_o falls. ram_we_n_o stays low for ceil(T_WP/clock) cycles (2 at the defaults), and address and data do not change while it is low.
- R5: For one cycle after ram_we_n_o rises, the RAM stays selected and the address and write data stay on the pins.
- R6: The controller never drives the data bus while ram_oe_n_o=0. After any read, at least ceil(T_HZ/clock) cycles with no one driving the bus pass before the controller drives it again.
- R7: A request is taken on a clock edge where req_valid_i=1 and req_ready_o=1. req_ready_o stays 0 until that access completes. A req_valid_i raised while req_ready_o=0 does nothing and does not alter memory.
- R8: Every completed access, read or write, gives exactly one cycle of rsp_valid_o=1.
- R9: Each wait count is the ceiling of the required time over CLK_PS, with a minimum of one. The 0 ps address setup therefore still costs one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured read data |
| ram_addr_o | output | 17 | RAM address pins |
| ram_cs_n_o | output | 1 | Low-true RAM select |
| ram_cs_o | output | 1 | High-true RAM select |
| ram_oe_n_o | output | 1 | Low-true RAM output enable |
| ram_we_n_o | output | 1 | Low-true RAM write strobe |
| ram_dq_io | inout | 8 | RAM data bus |

## Verification
The bench RAM model returns a garbage byte (0xEE) until 45 ns have passed since select and output enable were asserted with a steady address. A controller that samples one cycle early therefore returns 0xEE rather than the stored byte. The bench measures the length of every strobe, checks that address and data are set up before the write strobe falls and held one cycle after it rises, and counts the idle cycles between a read and the write that follows it. A missing setup, hold or turnaround phase shows up as a wrong count or as a corrupted byte when the location is read back. Request pulses raised while the controller is busy must leave memory untouched, and the addresses 0 and 0x1FFFF are exercised with complementary data patterns.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_HZ,
    ST_WR_SU,
    ST_WR_PULSE,
    ST_WR_HOLD
  } sram_st_e;

  // ceiling of t_ps / clk_ps, never below one cycle
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the phase
  assign expire_o = (cnt_q == CW'(1));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW    = 4,
  parameter int N_RD  = 3,
  parameter int N_HZ  = 1,
  parameter int N_SU  = 1,
  parameter int N_WP  = 2,
  parameter int N_WH  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic          expire_i,
  output sram_st_e      state_d_o,
  output logic          ready_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          done_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  sram_st_e state_q, state_d;
  logic     done_q;

  always_comb begin
    state_d   = state_q;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        state_d  = req_we_i ? ST_WR_SU : ST_RD_ACC;
      end
      ST_RD_ACC: if (expire_i) begin
        capture_o = 1'b1;
        state_d   = ST_RD_HZ;
      end
      ST_RD_HZ:    if (expire_i) state_d = ST_IDLE;
      ST_WR_SU:    if (expire_i) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (expire_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (expire_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_RD_ACC:   load_val_o = CW'(N_RD);
      ST_RD_HZ:    load_val_o = CW'(N_HZ);
      ST_WR_SU:    load_val_o = CW'(N_SU);
      ST_WR_PULSE: load_val_o = CW'(N_WP);
      ST_WR_HOLD:  load_val_o = CW'(N_WH);
      default:     load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture_o || (state_q == ST_WR_HOLD && expire_i);
    end
  end

  assign state_d_o = state_d;
  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = done_q;

endmodule

// File: rtl/sram_pin_io.sv
module sram_pin_io
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sram_st_e      state_d_i,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_cs_n_o,
  output logic          ram_cs_o,
  output logic          ram_oe_n_o,
  output logic          ram_we_n_o,
  output logic          drive_o,
  output logic [DW-1:0] bus_in_o,
  inout  wire  [DW-1:0] ram_dq_io
);

  logic [DW-1:0] wdata_q;
  logic          sel_d, oe_d, we_d, drv_d;

  // pins registered from next state so they switch glitch-free on the edge
  assign sel_d = (state_d_i != ST_IDLE) && (state_d_i != ST_RD_HZ);
  assign oe_d  = (state_d_i == ST_RD_ACC);
  assign we_d  = (state_d_i == ST_WR_PULSE);
  assign drv_d = (state_d_i == ST_WR_SU) || (state_d_i == ST_WR_PULSE) ||
                 (state_d_i == ST_WR_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      wdata_q    <= '0;
      ram_cs_n_o <= 1'b1;
      ram_cs_o   <= 1'b0;
      ram_oe_n_o <= 1'b1;
      ram_we_n_o <= 1'b1;
      drive_o    <= 1'b0;
    end else begin
      if (accept_i) begin
        ram_addr_o <= addr_i;
        wdata_q    <= wdata_i;
      end
      ram_cs_n_o <= !sel_d;
      ram_cs_o   <= sel_d;
      ram_oe_n_o <= !oe_d;
      ram_we_n_o <= !we_d;
      drive_o    <= drv_d;
    end
  end

  assign ram_dq_io = drive_o ? wdata_q : {DW{1'bz}};
  assign bus_in_o  = ram_dq_io;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_PS    = 20000,
  parameter int T_RC_PS   = 45000,
  parameter int T_AA_PS   = 45000,
  parameter int T_DOE_PS  = 20000,
  parameter int T_HZ_PS   = 15000,
  parameter int T_WP_PS   = 35000,
  parameter int T_AS_PS   = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_cs_n_o,
  output logic          ram_cs_o,
  output logic          ram_oe_n_o,
  output logic          ram_we_n_o,
  inout  wire  [DW-1:0] ram_dq_io
);

  localparam int N_RD  = max3(cyc_of(T_RC_PS, CLK_PS), cyc_of(T_AA_PS, CLK_PS),
                              cyc_of(T_DOE_PS, CLK_PS));
  localparam int N_HZ  = cyc_of(T_HZ_PS, CLK_PS);
  localparam int N_SU  = cyc_of(T_AS_PS, CLK_PS);
  localparam int N_WP  = cyc_of(T_WP_PS, CLK_PS);
  localparam int N_WH  = 1;
  localparam int N_MAX = max3(max3(N_RD, N_HZ, N_SU), N_WP, N_WH);
  localparam int CW    = $clog2(N_MAX + 1) + 1;

  sram_st_e      state_d;
  logic          expire, load, accept, capture, dq_drive;
  logic [CW-1:0] load_val;
  logic [DW-1:0] bus_in, rdata_q;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  sram_ctrl_fsm #(
    .CW(CW), .N_RD(N_RD), .N_HZ(N_HZ), .N_SU(N_SU), .N_WP(N_WP), .N_WH(N_WH)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .expire_i    (expire),
    .state_d_o   (state_d),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .done_o      (rsp_valid_o),
    .load_o      (load),
    .load_val_o  (load_val)
  );

  sram_pin_io #(.AW(AW), .DW(DW)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .ram_addr_o (ram_addr_o),
    .ram_cs_n_o (ram_cs_n_o),
    .ram_cs_o   (ram_cs_o),
    .ram_oe_n_o (ram_oe_n_o),
    .ram_we_n_o (ram_we_n_o),
    .drive_o    (dq_drive),
    .bus_in_o   (bus_in),
    .ram_dq_io  (ram_dq_io)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end

  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_cs_n_o,
  input logic          ram_cs_o,
  input logic          ram_oe_n_o,
  input logic          ram_we_n_o,
  input logic          dq_drive_i
);

  p_idle_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_cs_n_o && !ram_cs_o));

  p_read_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_oe_n_o && $past(!ram_oe_n_o)) |-> $stable(ram_addr_o));

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_oe_n_o && !ram_we_n_o));

  p_we_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_n_o) |-> ($stable(ram_addr_o) && $past(!ram_cs_n_o) && $past(dq_drive_i)));

  p_we_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> (dq_drive_i && !ram_cs_n_o && $stable(ram_addr_o)));

  p_no_drive_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_drive_i |-> ram_oe_n_o);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_n_o |=> !dq_drive_i);

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_cs_n_o  (ram_cs_n_o),
  .ram_cs_o    (ram_cs_o),
  .ram_oe_n_o  (ram_oe_n_o),
  .ram_we_n_o  (ram_we_n_o),
  .dq_drive_i  (dq_drive)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK_PS = 20000;
  // expected phase lengths, computed from the timing figures
  localparam int EXP_RD = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WP = (35000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_HZ = (15000 + CLK_PS - 1) / CLK_PS;
  // model data valid from the 3rd falling edge of the access (50 ns >= 45 ns)
  localparam int MDL_AGE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] ram_addr;
  logic        ram_cs_n, ram_cs, ram_oe_n, ram_we_n;
  wire  [7:0]  dq;

  int checks = 0, fails = 0;

  always #10ns clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ram_addr_o(ram_addr), .ram_cs_n_o(ram_cs_n), .ram_cs_o(ram_cs),
    .ram_oe_n_o(ram_oe_n), .ram_we_n_o(ram_we_n), .ram_dq_io(dq)
  );

  // ---------------- RAM model and pin monitor ----------------
  logic [7:0]  mem [int];
  logic [7:0]  mdl_val = 8'hEE;
  logic        mdl_drv;
  int          cyc = 0, age = 0;
  logic [16:0] age_addr = '0;
  int          oe_run = 0, last_oe_run = 0, we_run = 0, last_we_run = 0;
  int          last_rd_cyc = -1000, gap = 0;
  logic        setup_ok = 1'b0, hold_ok = 1'b0, we_stable = 1'b1;
  logic [16:0] wr_addr = '0, prev_addr = '0;
  logic [7:0]  wr_data = '0, prev_dq = '0;
  logic        prev_sel = 1'b0, prev_we_n = 1'b1;

  assign mdl_drv = !ram_cs_n && ram_cs && ram_we_n && !ram_oe_n;
  assign dq = mdl_drv ? mdl_val : 8'bz;

  function automatic logic [7:0] mem_rd(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    logic sel;
    cyc++;
    sel = !ram_cs_n && ram_cs;
    if (sel && ram_we_n && !ram_oe_n) begin
      if (age != 0 && ram_addr == age_addr) age++;
      else begin age = 1; age_addr = ram_addr; end
      mdl_val = (age >= MDL_AGE) ? mem_rd(ram_addr) : 8'hEE;
      last_rd_cyc = cyc;
    end else begin
      age = 0;
      mdl_val = 8'hEE;
    end
    if (!ram_oe_n) oe_run++;
    else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
    if (sel && !ram_we_n) begin
      if (we_run == 0) begin
        setup_ok = prev_sel && prev_we_n && (prev_addr == ram_addr) && (prev_dq == dq);
        gap = cyc - last_rd_cyc - 1;
        wr_addr = ram_addr;
        wr_data = dq;
      end
      if (ram_addr != wr_addr || dq != wr_data) we_stable = 1'b0;
      we_run++;
    end else if (we_run != 0) begin
      last_we_run = we_run;
      we_run = 0;
      hold_ok = sel && ram_we_n && ram_addr == wr_addr && dq == wr_data;
      mem[int'(wr_addr)] = wr_data;
    end
    prev_sel = sel; prev_we_n = ram_we_n; prev_addr = ram_addr; prev_dq = dq;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!rsp_valid && n < 50);
    check(rsp_valid, "R8 done seen", int'(rsp_valid), 1);
    @(negedge clk);
    check(!rsp_valid, "R8 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic issue(input logic we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    check(req_ready, "R7 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7 busy after accept", int'(req_ready), 0);
    check(!ram_cs_n && ram_cs, "R2 selected during access", int'({ram_cs_n, ram_cs}), 1);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    we_stable = 1'b1; setup_ok = 1'b0; hold_ok = 1'b0;
    issue(1'b1, a, d);
    wait_done();
    check(setup_ok, "R4 setup before strobe", int'(setup_ok), 1);
    check(we_stable, "R4 stable while strobe low", int'(we_stable), 1);
    check(last_we_run == EXP_WP, "R4 R9 strobe width", last_we_run, EXP_WP);
    check(hold_ok, "R5 hold after strobe", int'(hold_ok), 1);
    check(req_ready && ram_cs_n && !ram_cs, "R2 deselected when idle",
          int'({req_ready, ram_cs_n, ram_cs}), 3'b110);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
    issue(1'b0, a, 8'h00);
    wait_done();
    check(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
    check(last_oe_run == EXP_RD, "R3 R9 output-enable window", last_oe_run, EXP_RD);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 handshake reset", int'({req_ready, rsp_valid}), 2'b10);
    check(ram_cs_n && !ram_cs, "R1 deselect reset", int'({ram_cs_n, ram_cs}), 2'b10);
    check(ram_oe_n && ram_we_n, "R1 strobes reset", int'({ram_oe_n, ram_we_n}), 2'b11);
  endtask

  task automatic t_patterns();
    do_write(17'h00123, 8'hA5);
    do_write(17'h00124, 8'h5A);
    do_read(17'h00123, 8'hA5);
    do_read(17'h00124, 8'h5A);
  endtask

  task automatic t_edges();
    do_write(17'h00000, 8'hFF);
    do_write(17'h1FFFF, 8'h00);
    do_read(17'h1FFFF, 8'h00);
    do_read(17'h00000, 8'hFF);
    do_write(17'h1FFFF, 8'h81);
    do_read(17'h1FFFF, 8'h81);
  endtask

  task automatic t_turnaround();
    do_read(17'h00123, 8'hA5);
    do_write(17'h00200, 8'h3C);
    // gap counts idle, high-Z and setup cycles; the release portion must be >= EXP_HZ
    check(gap >= EXP_HZ + 1, "R6 turnaround after read", gap, EXP_HZ + 1);
    do_read(17'h00200, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    issue(1'b0, 17'h00123, 8'h00);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00123; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check(rsp_rdata == 8'hA5, "R7 read during busy pulse", rsp_rdata, 8'hA5);
    @(negedge clk);
    @(negedge clk);
    check(ram_cs_n && req_ready, "R7 busy request not started",
          int'({ram_cs_n, req_ready}), 2'b11);
    do_read(17'h00123, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_edges();
    t_turnaround();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule